// File: doc/BRIEF.md
# Iterative Waveform Playback Controller

This block plays a stored pattern out to a DAC under hardware timing. It produces the read address of the pattern buffer and an update strobe for each output sample. Samples are paced by an interval counted in timebase ticks. A fixed number of samples forms one waveform, and the block repeats that waveform a programmed number of times, or without end until a stop trigger arrives. The pattern contents, the DAC link and the loading of the buffer are handled elsewhere.

A start trigger begins playback after an optional hold-off delay. An optional pause can be placed between waveforms. When a waveform is shorter than the pattern, the read pointer is not rewound between iterations, so successive waveforms walk through the whole pattern. In retrigger mode the block returns to a waiting state after the programmed waveforms and plays them again on each later trigger. A stop trigger returns the block to idle at the next sample boundary.

The configuration inputs must stay stable while `busy` is high.

Top module: `wave_player`

## Requirements
- R1: After reset, `busy`, `upd_stb` and `wave_done` are 0 and `rd_addr` is 0.
- R2: A start trigger accepted in idle raises `busy`. The first `upd_stb` comes on the (D1+1)-th tick edge after the trigger edge, where D1 is `cfg_delay1`. With D1 = 0 this is the next tick.
- R3: `upd_stb` is a one-cycle pulse that only follows a cycle with `tick` high. Within a waveform, successive strobes are exactly max(`cfg_interval`,1) ticks apart.
- R4: A waveform is max(`cfg_count`,1) strobes. `wave_done` pulses together with the last strobe of each waveform and at no other time.
- R5: With `cfg_iter_en` = 1 and `cfg_retrig` = 0, exactly max(`cfg_iters`,1) waveforms are played. `busy` is 0 in the same cycle as the final strobe and stays 0, with no further strobes.
- R6: Between two waveforms of one run, the gap is `cfg_delay2`+1 ticks when `cfg_delay2` is nonzero, and max(`cfg_interval`,1) ticks when it is zero.
- R7: `rd_addr` holds the sample address while `upd_stb` is high. Successive samples use successive addresses, wrapping from L-1 to 0, where L is `cfg_pat_len` and a value of 0 means 2^ADDR_W. A start from idle begins at address 0. The address carries on across iterations and retriggers.
- R8: With `cfg_iter_en` = 0, playback continues with the same timing and addresses until a stop trigger.
- R9: A stop trigger during playback suppresses the next sample opportunity and returns to idle there, so no strobe appears on or after the stop edge. During a delay or while waiting for a retrigger, a stop trigger returns to idle at that edge.
- R10: With `cfg_retrig` = 1, after the programmed waveforms the block stays busy with no strobes. Each further start trigger replays the programmed waveforms with the same hold-off, continuing from the current address.
- R11: A start trigger that arrives during a delay or during playback is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable; all counting advances on cycles where it is high |
| start_trig | input | 1 | Start / retrigger pulse |
| stop_trig | input | 1 | Stop pulse |
| cfg_interval | input | CNT_W | Ticks between samples (0 acts as 1) |
| cfg_count | input | CNT_W | Samples per waveform (0 acts as 1) |
| cfg_iters | input | ITER_W | Waveforms per run (0 acts as 1) |
| cfg_iter_en | input | 1 | 1: finite number of waveforms; 0: run until stop |
| cfg_delay1 | input | CNT_W | Hold-off ticks after a trigger |
| cfg_delay2 | input | CNT_W | Pause ticks between waveforms |
| cfg_pat_len | input | ADDR_W+1 | Pattern length in entries (0 means 2^ADDR_W) |
| cfg_retrig | input | 1 | Wait for another trigger after each run |
| rd_addr | output | ADDR_W | Pattern read address |
| upd_stb | output | 1 | DAC update strobe |
| wave_done | output | 1 | Pulse with the last sample of each waveform |
| busy | output | 1 | High while not idle |

## Verification
The hardest situations to reach are those where two timing paths meet. One is a stop that lands between sample opportunities while the interval counter is part way through. Another is a retrigger that must resume from a carried-over address rather than zero. A third is the gap at a waveform boundary, which changes with the pause setting. The stimulus randomises interval, count, iterations, both delays, pattern length and a gappy tick. Every strobe's tick stamp and address is recorded and compared with a timeline computed from the requirements. Directed runs cover a 16-entry pattern with two samples per waveform over eight iterations, a stop mid-interval in endless mode, a stop during the hold-off, a start pulse during playback, and a two-trigger retrigger sequence.

// File: rtl/wave_player.sv
module wave_player #(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 32,
  parameter int ITER_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start_trig,
  input  logic              stop_trig,
  input  logic [CNT_W-1:0]  cfg_interval,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [ITER_W-1:0] cfg_iters,
  input  logic              cfg_iter_en,
  input  logic [CNT_W-1:0]  cfg_delay1,
  input  logic [CNT_W-1:0]  cfg_delay2,
  input  logic [ADDR_W:0]   cfg_pat_len,
  input  logic              cfg_retrig,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              upd_stb,
  output logic              wave_done,
  output logic              busy
);

  typedef enum logic [2:0] {S_IDLE, S_HOLD, S_PLAY, S_GAP, S_WAIT} st_t;

  st_t               st;
  logic [CNT_W-1:0]  ivl_cnt, dly_cnt, smp_cnt;
  logic [ITER_W-1:0] itr_cnt;
  logic [ADDR_W-1:0] ptr;
  logic              stop_pend;

  wire [CNT_W-1:0]  ivl   = (cfg_interval == '0) ? CNT_W'(1) : cfg_interval;
  wire [CNT_W-1:0]  ucnt  = (cfg_count == '0) ? CNT_W'(1) : cfg_count;
  wire [ITER_W-1:0] nit   = (cfg_iters == '0) ? ITER_W'(1) : cfg_iters;
  wire [ADDR_W-1:0] last  = ADDR_W'(cfg_pat_len - 1'b1);

  wire opp      = (st == S_PLAY) && tick && (ivl_cnt == '0);
  wire stopping = stop_trig || stop_pend;
  wire fire     = opp && !stopping;
  wire wv_end   = fire && (smp_cnt == ucnt - 1'b1);
  wire run_end  = wv_end && cfg_iter_en && (itr_cnt == nit - 1'b1);
  wire hold_go  = cfg_delay1 != '0;

  assign rd_addr = ptr;
  assign busy    = st != S_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ivl_cnt   <= '0;
      dly_cnt   <= '0;
      smp_cnt   <= '0;
      itr_cnt   <= '0;
      ptr       <= '0;
      stop_pend <= 1'b0;
      upd_stb   <= 1'b0;
      wave_done <= 1'b0;
    end else begin
      upd_stb   <= fire;
      wave_done <= wv_end;
      if (upd_stb) ptr <= (ptr == last) ? '0 : ptr + 1'b1;

      case (st)
        S_IDLE, S_WAIT: begin
          stop_pend <= 1'b0;
          if (st == S_WAIT && stop_trig) begin
            st <= S_IDLE;
          end else if (start_trig) begin
            itr_cnt <= '0;
            smp_cnt <= '0;
            if (st == S_IDLE) ptr <= '0;
            if (hold_go) begin
              dly_cnt <= cfg_delay1;
              st      <= S_HOLD;
            end else begin
              ivl_cnt <= '0;
              st      <= S_PLAY;
            end
          end
        end

        S_HOLD, S_GAP: begin
          if (stop_trig) begin
            st <= S_IDLE;
          end else if (tick) begin
            if (dly_cnt <= CNT_W'(1)) begin
              ivl_cnt <= '0;
              st      <= S_PLAY;
            end else begin
              dly_cnt <= dly_cnt - 1'b1;
            end
          end
        end

        S_PLAY: begin
          if (stop_trig) stop_pend <= 1'b1;
          if (opp) begin
            if (stopping) begin
              stop_pend <= 1'b0;
              st        <= S_IDLE;
            end else begin
              ivl_cnt <= ivl - 1'b1;
              if (wv_end) begin
                smp_cnt <= '0;
                itr_cnt <= itr_cnt + 1'b1;
                if (run_end) begin
                  st <= cfg_retrig ? S_WAIT : S_IDLE;
                end else if (cfg_delay2 != '0) begin
                  dly_cnt <= cfg_delay2;
                  st      <= S_GAP;
                end
              end else begin
                smp_cnt <= smp_cnt + 1'b1;
              end
            end
          end else if (tick) begin
            ivl_cnt <= ivl_cnt - 1'b1;
          end
        end

        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wave_player_chk.sv
module wave_player_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              busy,
  input logic              upd_stb,
  input logic              wave_done,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [ADDR_W:0]   cfg_pat_len
);

  logic [ADDR_W-1:0] top_addr;
  assign top_addr = ADDR_W'(cfg_pat_len - 1'b1);

  // R3
  stb_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> $past(tick));

  // R3
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> $past(busy));

  // R4
  done_with_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wave_done |-> upd_stb);

  // R7
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_pat_len != '0) |-> ({1'b0, rd_addr} < cfg_pat_len));

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb && $past(upd_stb)) |->
      (rd_addr == (($past(rd_addr) == top_addr) ? '0 : $past(rd_addr) + 1'b1)));

endmodule

bind wave_player wave_player_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .busy(busy), .upd_stb(upd_stb),
  .wave_done(wave_done), .rd_addr(rd_addr), .cfg_pat_len(cfg_pat_len)
);

// File: tb/wave_player_tb.sv
module wave_player_tb_top;
  localparam int ADDR_W = 6;
  localparam int CNT_W  = 32;
  localparam int ITER_W = 16;
  localparam int MAXEV  = 4096;

  logic clk = 0, rst_n = 0, tick = 1, start_trig = 0, stop_trig = 0;
  logic [CNT_W-1:0] cfg_interval = 1, cfg_count = 1, cfg_delay1 = 0, cfg_delay2 = 0;
  logic [ITER_W-1:0] cfg_iters = 1;
  logic cfg_iter_en = 1, cfg_retrig = 0;
  logic [ADDR_W:0] cfg_pat_len = 16;
  logic [ADDR_W-1:0] rd_addr;
  logic upd_stb, wave_done, busy;

  wave_player #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ITER_W(ITER_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start_trig(start_trig), .stop_trig(stop_trig),
    .cfg_interval(cfg_interval), .cfg_count(cfg_count), .cfg_iters(cfg_iters),
    .cfg_iter_en(cfg_iter_en), .cfg_delay1(cfg_delay1), .cfg_delay2(cfg_delay2),
    .cfg_pat_len(cfg_pat_len), .cfg_retrig(cfg_retrig),
    .rd_addr(rd_addr), .upd_stb(upd_stb), .wave_done(wave_done), .busy(busy)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, tc = 0, n_ev = 0;
  bit gappy = 0;
  int ev_tc [MAXEV];
  int ev_addr [MAXEV];
  bit ev_done [MAXEV];
  bit ev_busy [MAXEV];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tick) tc <= tc + 1;
    if (cyc == 190000) begin
      n_chk++; n_fail++;
      $display("FAIL R5 watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (upd_stb && n_ev < MAXEV) begin
      ev_tc[n_ev] = tc; ev_addr[n_ev] = rd_addr;
      ev_done[n_ev] = wave_done; ev_busy[n_ev] = busy;
      n_ev++;
    end
    tick <= gappy ? 1'($urandom % 2) : 1'b1;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  function automatic int eff(int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int plen();
    return (cfg_pat_len == 0) ? (1 << ADDR_W) : int'(cfg_pat_len);
  endfunction

  task automatic pulse_start(output int t0);
    start_trig = 1; step(1); t0 = tc; start_trig = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) step(1);
  endtask

  task automatic wait_ev(int n);
    for (int i = 0; i < 20000 && n_ev < n; i++) step(1);
  endtask

  task automatic check_burst(int e0, int a0, int n, int t0);
    int ie, ce, t, bad_intra, bad_inter, bad_addr, bad_done, fa, fe;
    ie = eff(int'(cfg_interval)); ce = eff(int'(cfg_count));
    bad_intra = 0; bad_inter = 0; bad_addr = 0; bad_done = 0; fa = 0; fe = 0;
    t = t0 + int'(cfg_delay1) + 1;
    chk(ev_tc[e0] - t0 == int'(cfg_delay1) + 1, "R2", "first strobe lag ticks",
        ev_tc[e0] - t0, int'(cfg_delay1) + 1);
    for (int k = 1; k < n; k++) begin
      int g;
      g = ev_tc[e0+k] - ev_tc[e0+k-1];
      if (k % ce == 0) begin
        if (g != ((cfg_delay2 != 0) ? int'(cfg_delay2) + 1 : ie)) bad_inter++;
      end else if (g != ie) begin
        bad_intra++; fa = g; fe = ie;
      end
    end
    for (int k = 0; k < n; k++) begin
      if (ev_addr[e0+k] != (a0 + k) % plen()) bad_addr++;
      if (ev_done[e0+k] != (k % ce == ce - 1)) bad_done++;
    end
    chk(bad_intra == 0, "R3", "sample spacing", fa, fe);
    chk(bad_inter == 0, "R6", "waveform gap mismatches", bad_inter, 0);
    chk(bad_addr == 0, "R7", "address mismatches", bad_addr, 0);
    chk(bad_done == 0, "R4", "wave_done mismatches", bad_done, 0);
  endtask

  task automatic run_finite();
    int t0, n, bad;
    n_ev = 0;
    pulse_start(t0);
    wait_idle();
    step(4);
    n = eff(int'(cfg_count)) * eff(int'(cfg_iters));
    chk(n_ev == n, "R5", "strobe total", n_ev, n);
    if (n_ev == n) begin
      check_burst(0, 0, n, t0);
      bad = 0;
      for (int k = 0; k < n - 1; k++) if (!ev_busy[k]) bad++;
      if (ev_busy[n-1]) bad++;
      chk(bad == 0, "R5", "busy timing mismatches", bad, 0);
    end
  endtask

  initial begin
    int t0, n0;
    void'($urandom(32'd4242));
    step(3);
    rst_n = 1;
    step(1);
    chk(!busy && !upd_stb && !wave_done, "R1", "idle outputs", {busy, upd_stb, wave_done}, 0);
    chk(rd_addr == 0, "R1", "reset address", rd_addr, 0);

    // R7 16-entry pattern, 2 samples per waveform, 8 iterations
    cfg_interval = 2; cfg_count = 2; cfg_iters = 8; cfg_pat_len = 16;
    cfg_delay1 = 0; cfg_delay2 = 0;
    run_finite();
    chk(ev_addr[15] == 15, "R7", "last address of full cycle", ev_addr[15], 15);

    // R2 R6 with both delays, gappy tick; rerun starts at address 0
    gappy = 1;
    cfg_interval = 3; cfg_count = 3; cfg_iters = 2; cfg_pat_len = 5;
    cfg_delay1 = 3; cfg_delay2 = 2;
    run_finite();
    run_finite();
    chk(ev_addr[0] == 0, "R7", "restart address", ev_addr[0], 0);

    for (int r = 0; r < 16; r++) begin
      gappy = 1'($urandom % 2);
      cfg_interval = $urandom % 5; cfg_count = $urandom % 6;
      cfg_iters = ITER_W'($urandom % 4); cfg_delay1 = $urandom % 5;
      cfg_delay2 = $urandom % 4; cfg_pat_len = (ADDR_W+1)'($urandom % 21);
      run_finite();
    end

    // R11 start during playback ignored
    gappy = 0;
    cfg_interval = 2; cfg_count = 4; cfg_iters = 3; cfg_delay1 = 1; cfg_delay2 = 2;
    cfg_pat_len = 6;
    n_ev = 0;
    pulse_start(t0);
    wait_ev(3);
    chk(busy, "R11", "busy before extra start", busy, 1);
    start_trig = 1; step(1); start_trig = 0;
    wait_idle(); step(4);
    chk(n_ev == 12, "R11", "strobe total with extra start", n_ev, 12);
    if (n_ev == 12) check_burst(0, 0, 12, t0);

    // R8 R9 endless run, stop mid-interval
    cfg_iter_en = 0; cfg_interval = 3; cfg_count = 3; cfg_delay1 = 0; cfg_delay2 = 0;
    cfg_pat_len = 7;
    n_ev = 0;
    pulse_start(t0);
    wait_ev(20);
    step(1);
    chk(busy, "R8", "still busy after many waveforms", busy, 1);
    n0 = n_ev;
    check_burst(0, 0, n0, t0);
    stop_trig = 1; step(1); stop_trig = 0;
    step(8);
    chk(n_ev == n0, "R9", "strobes after stop", n_ev, n0);
    chk(!busy, "R9", "busy after stop in playback", busy, 0);

    // R9 stop during hold-off
    cfg_iter_en = 1; cfg_delay1 = 50;
    n_ev = 0;
    pulse_start(t0);
    step(5);
    stop_trig = 1; step(1); stop_trig = 0;
    chk(!busy, "R9", "busy after stop in hold-off", busy, 0);
    step(60);
    chk(n_ev == 0, "R9", "strobes after hold-off stop", n_ev, 0);

    // R10 retrigger
    gappy = 1;
    cfg_retrig = 1; cfg_interval = 2; cfg_count = 3; cfg_iters = 2; cfg_delay1 = 1;
    cfg_delay2 = 0; cfg_pat_len = 4;
    n_ev = 0;
    pulse_start(t0);
    wait_ev(6);
    step(12);
    chk(busy, "R10", "busy while waiting", busy, 1);
    chk(n_ev == 6, "R10", "strobes in first run", n_ev, 6);
    if (n_ev == 6) check_burst(0, 0, 6, t0);
    pulse_start(t0);
    wait_ev(12);
    step(12);
    chk(n_ev == 12, "R10", "strobes after retrigger", n_ev, 12);
    if (n_ev == 12) check_burst(6, 6, 6, t0);
    stop_trig = 1; step(1); stop_trig = 0;
    chk(!busy, "R9", "busy after stop while waiting", busy, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule